// File: doc/BRIEF.md
# OTP Memory Program-and-Verify Sequencer

This controller writes a byte-wide one-time-programmable memory over an address range. Each byte gets 1 ms chip-enable pulses, and the byte is read back after every pulse. Pulses repeat until the read-back matches, up to 25 attempts. Once it matches, the controller gives the byte one reinforcing pulse three times as long as the pulses it needed, then reads it back again. When every byte is programmed, the controller lowers its programming-supply request and reads the whole range once more.

A host puts the inclusive range on `addr_lo`/`addr_hi` and pulses `start`. The byte to write comes from a combinational source indexed by `src_addr`. The memory side consists of the strobes (`mem_ce_n`, `mem_oe_n`), the address, a data bus split into output, output-enable and input, and a `vpp_req` level that asks external circuitry for the raised programming supply. The run ends in one of two states:
- `done`, when every byte was programmed and verified.
- `fail`, which also holds the failing address and the byte that was read back.

The millisecond is counted in clock cycles, set by `CYC_PER_MS`. The read sample point is set at run time by `acc_dly`.

Top module: `eprom_pgm_seq`

## Requirements
- R1: After reset, `mem_ce_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, and `vpp_req`, `busy`, `done`, `fail` and `mem_addr` are 0.
- R2: `start` is accepted only when the block is idle, done or failed, and only when `addr_lo` <= `addr_hi`. At any other time `start` has no effect on any output.
- R3: Once `start` is accepted, `vpp_req` and `busy` rise. For exactly `CYC_PER_MS` cycles both strobes stay high, and then the first pulse begins.
- R4: A programming pulse lasts exactly `CYC_PER_MS` cycles. During it, `mem_ce_n` is 0, `mem_oe_n` is 1, `mem_dq_oe` is 1, `mem_dq_out` equals the source byte, and `mem_addr` does not change.
- R5: After each pulse comes a read-back of `acc_dly`+1 cycles. During it, `mem_oe_n` is 0, `mem_ce_n` is 1 and the bus is released. `mem_dq_in` is compared with the source byte in the last cycle.
- R6: If the read-back does not match, another pulse follows, up to `MAX_TRY` (25) pulses per byte. A mismatch after the 25th pulse sends the block to the fail state.
- R7: A byte that matches after n pulses gets one pulse of 3·n·`CYC_PER_MS` cycles, followed by another read-back. A mismatch on that read-back sends the block to the fail state.
- R8: When that second read-back matches, the address moves up by one and the attempt count restarts for the next byte. After the byte at `addr_hi`, the block enters final verification.
- R9: Final verification drops `vpp_req` and holds both strobes high for `CYC_PER_MS` cycles with `mem_addr` = `addr_lo`. It then reads each address from `addr_lo` to `addr_hi` once, for `acc_dly`+1 cycles each. Any mismatch sends the block to the fail state.
- R10: When every address passes final verification, `done` goes to 1 and `busy` to 0. `done` stays at 1 until the next accepted `start`, and `done` and `fail` are never both 1.
- R11: In the fail state:
  - `fail` is 1.
  - `busy` and `vpp_req` are 0.
  - Both strobes are high.
  - `fail_addr` holds the failing address and `fail_data` holds the byte that was read back.
  These hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run over the given range |
| addr_lo | input | AW | First address of the range |
| addr_hi | input | AW | Last address of the range (inclusive) |
| acc_dly | input | ACW | Read-back access delay in extra cycles |
| src_addr | output | AW | Address of the byte wanted from the source |
| src_data | input | DW | Byte to program at `src_addr` |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data driven to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, low during a programming pulse |
| mem_oe_n | output | 1 | Output enable, low during a read |
| vpp_req | output | 1 | Request for the raised programming supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with every byte verified |
| fail | output | 1 | Run stopped on an unprogrammable or unstable byte |
| fail_addr | output | AW | Address at which the run failed |
| fail_data | output | DW | Byte read back at the failure |

## Verification
The bench model memory can make a byte take more than one pulse. It covers these cases:
- A byte that takes exactly 25 pulses must still pass. A design with an off-by-one attempt limit would fail it wrongly.
- A byte that never matches must fail after exactly 25 pulses. A limit set one too high would give an extra pulse.
- A byte that is corrupted by its reinforcing pulse checks that the second read-back is really compared.
- A byte that reads wrong only once the supply request is low can be caught only by a true final pass. A design that skipped the final pass, or kept the supply raised during it, would report `done` for it.
- A `start` given mid-run, and one with an inverted range, must leave every output unchanged. A design that accepted either would restart or jump address.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RAMP, S_PGM, S_RD, S_OVR, S_RD2, S_DROP, S_FV, S_DONE, S_FAIL
  } eps_state_e;
endpackage

// File: rtl/eps_ms_timer.sv
// Millisecond timebase: counts whole milliseconds of CYC_PER_MS cycles.
// Loading n gives an interval of (n+1) milliseconds ending with expired high.
module eps_ms_timer #(
  parameter int CYC_PER_MS = 10000,
  parameter int MSW        = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [MSW-1:0] load_ms,
  output logic           expired
);
  localparam int TW = $clog2(CYC_PER_MS + 1);
  localparam logic [TW-1:0] TICK_TOP = TW'(CYC_PER_MS - 1);

  logic [TW-1:0]  tick_q, tick_d;
  logic [MSW-1:0] ms_q, ms_d;

  always_comb begin
    tick_d = tick_q;
    ms_d   = ms_q;
    if (load) begin
      tick_d = TICK_TOP;
      ms_d   = load_ms;
    end else if (tick_q == '0) begin
      if (ms_q != '0) begin
        ms_d   = ms_q - MSW'(1);
        tick_d = TICK_TOP;
      end
    end else begin
      tick_d = tick_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      ms_q   <= '0;
    end else begin
      tick_q <= tick_d;
      ms_q   <= ms_d;
    end
  end

  assign expired = (tick_q == '0) && (ms_q == '0);
endmodule

// File: rtl/eps_acc_timer.sv
// Read access delay: loading v gives an interval of v+1 cycles.
module eps_acc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eps_try_ctr.sv
// Per-byte programming attempt counter.
module eps_try_ctr #(
  parameter int MAX_TRY = 25,
  parameter int TRW     = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           bump,
  output logic [TRW-1:0] count,
  output logic           at_max
);
  logic [TRW-1:0] cnt_d;
  logic           cnt_en;

  always_comb begin
    cnt_en = restart | bump;
    cnt_d  = restart ? TRW'(1) : count + TRW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end

  assign at_max = (count == TRW'(MAX_TRY));
endmodule

// File: rtl/eprom_pgm_seq.sv
module eprom_pgm_seq #(
  parameter int AW         = 14,
  parameter int DW         = 8,
  parameter int CYC_PER_MS = 10000,
  parameter int MAX_TRY    = 25,
  parameter int ACW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_lo,
  input  logic [AW-1:0] addr_hi,
  input  logic [ACW-1:0] acc_dly,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          vpp_req,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_data
);
  import eps_pkg::*;

  localparam int TRW = $clog2(MAX_TRY + 1);
  localparam int MSW = $clog2(3 * MAX_TRY + 1);

  eps_state_e     state_q, state_d;
  logic [AW-1:0]  addr_q, addr_d, lo_q, hi_q;
  logic           rng_en, fail_ld;
  logic           ms_ld, ms_exp, acc_ld, acc_exp;
  logic [MSW-1:0] ms_val;
  logic           try_restart, try_bump, try_max;
  logic [TRW-1:0] try_cnt;
  logic           match, start_ok;

  eps_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MSW(MSW)) u_ms (
    .clk(clk), .rst_n(rst_n), .load(ms_ld), .load_ms(ms_val), .expired(ms_exp)
  );

  eps_acc_timer #(.W(ACW)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(acc_ld), .load_val(acc_dly), .expired(acc_exp)
  );

  eps_try_ctr #(.MAX_TRY(MAX_TRY), .TRW(TRW)) u_try (
    .clk(clk), .rst_n(rst_n), .restart(try_restart), .bump(try_bump),
    .count(try_cnt), .at_max(try_max)
  );

  assign match    = (mem_dq_in == src_data);
  assign start_ok = start && (addr_lo <= addr_hi);

  // Next-state and control decode
  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    rng_en      = 1'b0;
    fail_ld     = 1'b0;
    ms_ld       = 1'b0;
    ms_val      = '0;
    acc_ld      = 1'b0;
    try_restart = 1'b0;
    try_bump    = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start_ok) begin
          state_d = S_RAMP;
          addr_d  = addr_lo;
          rng_en  = 1'b1;
          ms_ld   = 1'b1;
        end
      end
      S_RAMP: begin
        if (ms_exp) begin
          state_d     = S_PGM;
          ms_ld       = 1'b1;
          try_restart = 1'b1;
        end
      end
      S_PGM: begin
        if (ms_exp) begin
          state_d = S_RD;
          acc_ld  = 1'b1;
        end
      end
      S_RD: begin
        if (acc_exp) begin
          if (match) begin
            state_d = S_OVR;
            ms_ld   = 1'b1;
            ms_val  = MSW'(try_cnt) * MSW'(3) - MSW'(1);
          end else if (try_max) begin
            state_d = S_FAIL;
            fail_ld = 1'b1;
          end else begin
            state_d  = S_PGM;
            ms_ld    = 1'b1;
            try_bump = 1'b1;
          end
        end
      end
      S_OVR: begin
        if (ms_exp) begin
          state_d = S_RD2;
          acc_ld  = 1'b1;
        end
      end
      S_RD2: begin
        if (acc_exp) begin
          if (!match) begin
            state_d = S_FAIL;
            fail_ld = 1'b1;
          end else if (addr_q == hi_q) begin
            state_d = S_DROP;
            addr_d  = lo_q;
            ms_ld   = 1'b1;
          end else begin
            state_d     = S_PGM;
            addr_d      = addr_q + AW'(1);
            ms_ld       = 1'b1;
            try_restart = 1'b1;
          end
        end
      end
      S_DROP: begin
        if (ms_exp) begin
          state_d = S_FV;
          acc_ld  = 1'b1;
        end
      end
      S_FV: begin
        if (acc_exp) begin
          if (!match) begin
            state_d = S_FAIL;
            fail_ld = 1'b1;
          end else if (addr_q == hi_q) begin
            state_d = S_DONE;
          end else begin
            addr_d = addr_q + AW'(1);
            acc_ld = 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (rng_en) begin
      lo_q <= addr_lo;
      hi_q <= addr_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_addr <= '0;
      fail_data <= '0;
    end else if (fail_ld) begin
      fail_addr <= addr_q;
      fail_data <= mem_dq_in;
    end
  end

  // Output decode from the state register
  always_comb begin
    mem_ce_n  = !(state_q == S_PGM || state_q == S_OVR);
    mem_dq_oe = (state_q == S_PGM || state_q == S_OVR);
    mem_oe_n  = !(state_q == S_RD || state_q == S_RD2 || state_q == S_FV);
    vpp_req   = (state_q == S_RAMP || state_q == S_PGM || state_q == S_RD ||
                 state_q == S_OVR  || state_q == S_RD2);
    busy      = !(state_q == S_IDLE || state_q == S_DONE || state_q == S_FAIL);
    done      = (state_q == S_DONE);
    fail      = (state_q == S_FAIL);
  end

  assign src_addr   = addr_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = src_data;
endmodule

// File: rtl/eps_chk.sv
module eps_chk #(
  parameter int AW      = 14,
  parameter int TRW     = 5,
  parameter int MAX_TRY = 25
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_ce_n,
  input logic           mem_oe_n,
  input logic           mem_dq_oe,
  input logic           vpp_req,
  input logic           busy,
  input logic           done,
  input logic           fail,
  input logic [AW-1:0]  mem_addr,
  input logic [TRW-1:0] try_cnt
);
  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_ce_n && !mem_oe_n));
  // R5
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));
  // R9
  pulse_needs_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_req |-> mem_ce_n);
  // R11
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!vpp_req && !busy && mem_ce_n && mem_oe_n));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done || busy));
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  // R6
  try_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    try_cnt <= TRW'(MAX_TRY));
endmodule

bind eprom_pgm_seq eps_chk #(.AW(AW), .TRW(TRW), .MAX_TRY(MAX_TRY)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .vpp_req(vpp_req), .busy(busy), .done(done),
  .fail(fail), .mem_addr(mem_addr), .try_cnt(try_cnt)
);

// File: tb/sim_eprom_pgm_seq.sv
`timescale 1ns/1ps
module sim_eprom_pgm_seq;
  localparam int AW = 6, DW = 8, T = 4, MAXT = 25, ACW = 3;
  localparam int N = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [AW-1:0] addr_lo, addr_hi, src_addr, mem_addr, fail_addr;
  logic [ACW-1:0] acc_dly;
  logic [DW-1:0] src_data, mem_dq_out, mem_dq_in, fail_data;
  logic mem_dq_oe, mem_ce_n, mem_oe_n, vpp_req, busy, done, fail;

  always #2 clk = ~clk;

  eprom_pgm_seq #(.AW(AW), .DW(DW), .CYC_PER_MS(T), .MAX_TRY(MAXT), .ACW(ACW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .acc_dly(acc_dly), .src_addr(src_addr), .src_data(src_data),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .vpp_req(vpp_req), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_data(fail_data)
  );

  // Behavioural memory: image, pulses needed, pulses received, weak/drifting bytes
  logic [DW-1:0] img [N];
  int  need [N];
  int  cnt  [N];
  bit  frag [N];
  bit  drift[N];
  int  nvec = 0, nerr = 0;

  assign src_data = img[src_addr];

  always @(posedge mem_ce_n) if (rst_n) cnt[mem_addr] = cnt[mem_addr] + 1;

  always_comb begin
    if (cnt[mem_addr] < need[mem_addr])                           mem_dq_in = ~img[mem_addr];
    else if (frag[mem_addr] && cnt[mem_addr] > need[mem_addr])    mem_dq_in = img[mem_addr] ^ 8'h01;
    else if (drift[mem_addr] && !vpp_req)                         mem_dq_in = img[mem_addr] ^ 8'h80;
    else                                                          mem_dq_in = img[mem_addr];
  end

  task automatic chk(string tag, bit ce, bit oe, bit den, bit vpp, bit bsy, bit dn, bit fl, int a);
    logic [6:0] got, exp;
    got = {mem_ce_n, mem_oe_n, mem_dq_oe, vpp_req, busy, done, fail};
    exp = {ce, oe, den, vpp, bsy, dn, fl};
    nvec++;
    if (got !== exp || mem_addr !== AW'(a) || mem_dq_out !== img[a]) begin
      nerr++;
      $display("FAIL %s t=%0t ce,oe,den,vpp,busy,done,fail=%b addr=%0d dq=%h exp %b addr=%0d dq=%h",
               tag, $time, got, mem_addr, mem_dq_out, exp, a, img[a]);
    end
  endtask

  task automatic hold(int n, string tag, bit ce, bit oe, bit den, bit vpp, bit bsy, bit dn, bit fl, int a);
    repeat (n) begin
      chk(tag, ce, oe, den, vpp, bsy, dn, fl, a);
      @(negedge clk);
    end
  endtask

  task automatic expect_fail(int a, logic [DW-1:0] d);
    nvec++;
    if (fail_addr !== AW'(a) || fail_data !== d) begin
      nerr++;
      $display("FAIL R11 fail_addr=%0d fail_data=%h exp %0d %h", fail_addr, fail_data, a, d);
    end
    hold(3, "R11", 1, 1, 0, 0, 0, 0, 1, a);
  endtask

  task automatic run_case(int lo, int hi, int acc, bit poke);
    int tries;
    for (int i = 0; i < N; i++) cnt[i] = 0;
    acc_dly = ACW'(acc);
    addr_lo = AW'(lo); addr_hi = AW'(hi); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) fork
      begin
        repeat (T + 2) @(negedge clk);
        start = 1'b1; addr_lo = '0; addr_hi = AW'(N - 1);
        @(negedge clk);
        start = 1'b0;
      end
    join_none
    hold(T, "R3", 1, 1, 0, 1, 1, 0, 0, lo);
    for (int a = lo; a <= hi; a++) begin
      tries = (need[a] > MAXT) ? MAXT : need[a];
      for (int k = 0; k < tries; k++) begin
        hold(T, "R4", 0, 1, 1, 1, 1, 0, 0, a);
        hold(acc + 1, "R5", 1, 0, 0, 1, 1, 0, 0, a);
      end
      if (need[a] > MAXT) begin expect_fail(a, ~img[a]); return; end  // R6
      hold(3 * tries * T, "R7", 0, 1, 1, 1, 1, 0, 0, a);
      hold(acc + 1, "R7", 1, 0, 0, 1, 1, 0, 0, a);
      if (frag[a]) begin expect_fail(a, img[a] ^ 8'h01); return; end
    end
    hold(T, "R9", 1, 1, 0, 0, 1, 0, 0, lo);  // R8 range finished, final pass begins
    for (int a = lo; a <= hi; a++) begin
      hold(acc + 1, "R9", 1, 0, 0, 0, 1, 0, 0, a);
      if (drift[a]) begin expect_fail(a, img[a] ^ 8'h80); return; end
    end
    hold(3, "R10", 1, 1, 0, 0, 0, 1, 0, hi);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      img[i] = DW'(8'h35 + i * 7); need[i] = 1; frag[i] = 0; drift[i] = 0; cnt[i] = 0;
    end
    need[1] = 2; need[3] = 3;          // multi-pulse bytes
    need[5] = MAXT;                    // R6 boundary: passes on the last allowed pulse
    need[9] = MAXT + 5;                // R6 never programs
    frag[10] = 1;                      // R7 weakened by the long pulse
    drift[13] = 1;                     // R9 only wrong at normal supply
    rst_n = 1'b0; start = 1'b0; addr_lo = '0; addr_hi = '0; acc_dly = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hold(2, "R1", 1, 1, 0, 0, 0, 0, 0, 0);
    run_case(0, 3, 2, 0);                        // R4 R5 R8 R10
    addr_lo = 6'd5; addr_hi = 6'd2; start = 1'b1; // R2 inverted range ignored
    @(negedge clk);
    start = 1'b0;
    hold(4, "R2", 1, 1, 0, 0, 0, 1, 0, 3);
    run_case(4, 5, 0, 0);                        // R6 25 pulses still pass
    run_case(8, 9, 1, 0);                        // R6 fail after 25
    run_case(10, 11, 3, 0);                      // R7 fail on second read-back
    run_case(12, 14, 2, 1);                      // R2 mid-run start, R9 final pass fail
    addr_lo = 6'd7; addr_hi = 6'd1; start = 1'b1; // R2 inverted range ignored in fail state
    @(negedge clk);
    start = 1'b0;
    hold(3, "R2", 1, 1, 0, 0, 0, 0, 1, 13);
    run_case(0, 0, 0, 0);                        // R11 cleared by new start, single byte
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule